// File: doc/BRIEF.md
# Banked Bit-Addressable Data RAM

This block is the on-chip data store of a small controller core. It holds 128 bytes of general RAM at byte addresses 00H–7FH and a 128-byte stand-in register file for the special-register area at 80H–FFH. Every access is driven by a 4-bit operation code on a single cycle. The result of a read appears on a registered output one clock after the operation.

The same storage can be reached in several ways:
- **Byte access** uses a direct 8-bit address.
- **Register access** takes a 3-bit index and places it inside the register bank chosen by a 2-bit bank input.
- **Indirect access** uses the content of register 0 or 1 of the active bank as the RAM address.
- **Single-bit access** uses an 8-bit bit address. It can set a bit, clear a bit or read a bit. Set and clear change only the addressed bit of the byte.

An 8-bit stack pointer supports push and pop. Push moves the pointer up first and then writes. Pop reads first and then moves the pointer down. The stack stays inside the RAM: it cannot grow past 7FH and it cannot go below 00H.

Top module: `bitram_core`

## Requirements
- R1: After reset the stack pointer is 07H, `rdata` and `rbit` are 0, and every byte 00H–FFH reads as 00H.
- R2: Op 2 (byte write) stores `wdata` at `addr`. Op 1 (byte read) presents the byte at `addr` on `rdata` after the next rising edge. Addresses 00H–7FH (RAM) and 80H–FFH (special area) are separate storage.
- R3: Op 4 (register write) and op 3 (register read) access byte `bank_sel*8 + reg_idx`. For example, bank 3 with index 5 is byte 1DH, and bank 3 with index 0 is byte 18H.
- R4: Op 9 (bit read) puts the addressed bit on `rbit` after the next edge. A bit address b below 80H selects bit b[2:0] of byte 20H + (b>>3), so bit 67H is bit 7 of 2CH. A bit address of 80H or above selects bit b[2:0] of byte (b with its low 3 bits cleared), so bit F7H is bit 7 of F0H.
- R5: Op 7 (bit set) writes 1 and op 8 (bit clear) writes 0 to the bit addressed as in R4. The other 7 bits of that byte are unchanged.
- R6: Op 6 (indirect write) and op 5 (indirect read) use as their address bits [6:0] of bank register R0 (when `reg_idx[0]`=0) or R1 (when `reg_idx[0]`=1) of the active bank. Bit 7 of the pointer is ignored, so the access always lands in RAM.
- R7: Op 10 (push) increments the stack pointer and then writes `wdata` at the new pointer. When the pointer is already 7FH, the push is refused: the pointer stays the same and no byte is written.
- R8: Op 11 (pop) presents the byte at the stack pointer on `rdata` and then decrements the pointer. When the pointer is 00H, a pop reads byte 00H and the pointer stays at 00H.
- R9: `rdata` changes only on ops 1, 3, 5 and 11. `rbit` changes only on op 9. Op 0 (no operation) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code (values listed in the requirements) |
| addr | input | 8 | Direct byte address, or bit address for bit operations |
| reg_idx | input | 3 | Bank register index; bit 0 selects R0 or R1 for indirect access |
| bank_sel | input | 2 | Active register bank |
| wdata | input | 8 | Write data for byte, register, indirect and push operations |
| rdata | output | 8 | Registered read data |
| rbit | output | 1 | Registered result of a bit read |
| stk_ptr | output | 8 | Current stack pointer |

## Verification
The hardest conditions to reach from the ports are the two stack limits. A full stack can only be reached by 120 consecutive pushes from the reset pointer, and an empty stack can only be reached by popping the pointer all the way down. The bench therefore fills the stack to 7FH. It then attempts one more push and confirms that nothing was written, by reading back special byte 80H, which is the address a wrongly accepted push would have hit. It then pops all the way to 00H and pops once more. Pointer aliasing is reached by loading a bank register with a value whose bit 7 is set. The bench then confirms that the indirect write lands in RAM and that the special byte with the same low bits is left untouched.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_RDB  = 4'd1,
    OP_WRB  = 4'd2,
    OP_RDR  = 4'd3,
    OP_WRR  = 4'd4,
    OP_RDI  = 4'd5,
    OP_WRI  = 4'd6,
    OP_BSET = 4'd7,
    OP_BCLR = 4'd8,
    OP_BRD  = 4'd9,
    OP_PUSH = 4'd10,
    OP_POP  = 4'd11
  } op_e;

  // Byte holding bank register idx of the given bank.
  function automatic logic [7:0] reg_byte(input logic [1:0] bank, input logic [2:0] idx);
    return {3'b000, bank, idx};
  endfunction

  // Byte holding a bit: RAM bit area below 80H, special area above.
  function automatic logic [7:0] bit_byte(input logic [7:0] b);
    return b[7] ? {b[7:3], 3'b000} : {4'b0010, b[6:3]};
  endfunction

  // Replace one bit of a byte.
  function automatic logic [7:0] put_bit(input logic [7:0] v, input logic [2:0] pos,
                                         input logic val);
    logic [7:0] r;
    r = v;
    r[pos] = val;
    return r;
  endfunction

endpackage

// File: rtl/bitram_bytes.sv
module bitram_bytes #(
  parameter int DEPTH = 128,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRD*AW-1:0] rd_a,
  output logic [NRD*8-1:0]  rd_q,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [7:0]        wd
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_q[p*8 +: 8] = mem[rd_a[p*AW +: AW]];
  end

endmodule

// File: rtl/bitram_stack.sv
module bitram_stack #(
  parameter logic [7:0] INIT = 8'h07,
  parameter logic [7:0] TOP  = 8'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_req,
  input  logic       pop_req,
  output logic [7:0] sp,
  output logic       push_ok,
  output logic [7:0] push_addr
);

  assign push_ok   = push_req && (sp != TOP);
  assign push_addr = sp + 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)                      sp <= INIT;
    else if (push_ok)                sp <= push_addr;
    else if (pop_req && sp != 8'h00) sp <= sp - 8'd1;
  end

endmodule

// File: rtl/bitram_core.sv
module bitram_core
  import bitram_pkg::*;
#(
  parameter int         RAM_BYTES = 128,
  parameter int         SFR_BYTES = 128,
  parameter logic [7:0] SP_INIT   = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [7:0] addr,
  input  logic [2:0] reg_idx,
  input  logic [1:0] bank_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rbit,
  output logic [7:0] stk_ptr
);

  localparam int         RAW      = $clog2(RAM_BYTES);
  localparam int         SAW      = $clog2(SFR_BYTES);
  localparam logic [7:0] STK_TOP  = 8'(RAM_BYTES - 1);

  op_e        op_c;
  logic [7:0] ptr_byte, ptr_q, eff, cur_byte, wr_val;
  logic [7:0] ram_qa, sfr_qa;
  logic       wr_en, ram_we, sfr_we;
  logic       stk_push_ok;
  logic [7:0] stk_push_addr;
  logic       rd_evt, bit_rd_evt;

  assign op_c     = op_e'(op);
  assign ptr_byte = reg_byte(bank_sel, {2'b00, reg_idx[0]});

  always_comb begin
    eff = addr;
    unique case (op_c)
      OP_RDR, OP_WRR:           eff = reg_byte(bank_sel, reg_idx);
      OP_RDI, OP_WRI:           eff = {1'b0, ptr_q[6:0]};
      OP_BSET, OP_BCLR, OP_BRD: eff = bit_byte(addr);
      OP_PUSH:                  eff = stk_push_addr;
      OP_POP:                   eff = stk_ptr;
      default:                  eff = addr;
    endcase
  end

  assign cur_byte = eff[7] ? sfr_qa : ram_qa;

  always_comb begin
    wr_en  = 1'b0;
    wr_val = wdata;
    unique case (op_c)
      OP_WRB, OP_WRR, OP_WRI: wr_en = 1'b1;
      OP_BSET: begin wr_en = 1'b1; wr_val = put_bit(cur_byte, addr[2:0], 1'b1); end
      OP_BCLR: begin wr_en = 1'b1; wr_val = put_bit(cur_byte, addr[2:0], 1'b0); end
      OP_PUSH: wr_en = stk_push_ok;
      default: wr_en = 1'b0;
    endcase
  end

  assign ram_we     = wr_en && !eff[7];
  assign sfr_we     = wr_en &&  eff[7];
  assign rd_evt     = (op_c == OP_RDB) || (op_c == OP_RDR) || (op_c == OP_RDI) || (op_c == OP_POP);
  assign bit_rd_evt = (op_c == OP_BRD);

  bitram_bytes #(.DEPTH(RAM_BYTES), .NRD(2)) ram_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_a  ({ptr_byte[RAW-1:0], eff[RAW-1:0]}),
    .rd_q  ({ptr_q, ram_qa}),
    .we    (ram_we),
    .wa    (eff[RAW-1:0]),
    .wd    (wr_val)
  );

  bitram_bytes #(.DEPTH(SFR_BYTES), .NRD(1)) sfr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_a  (eff[SAW-1:0]),
    .rd_q  (sfr_qa),
    .we    (sfr_we),
    .wa    (eff[SAW-1:0]),
    .wd    (wr_val)
  );

  bitram_stack #(.INIT(SP_INIT), .TOP(STK_TOP)) stk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (op_c == OP_PUSH),
    .pop_req   (op_c == OP_POP),
    .sp        (stk_ptr),
    .push_ok   (stk_push_ok),
    .push_addr (stk_push_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rbit  <= 1'b0;
    end else begin
      if (rd_evt)     rdata <= cur_byte;
      if (bit_rd_evt) rbit  <= cur_byte[addr[2:0]];
    end
  end

endmodule

// File: rtl/bitram_chk.sv
module bitram_chk
  import bitram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op,
  input logic [7:0] sp,
  input logic [7:0] rdata,
  input logic       rbit,
  input logic       push_ok
);

  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp == $past(sp) + 8'd1);

  // R7
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && sp == 8'h7F) |=> $stable(sp));

  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && sp != 8'h00) |=> sp == $past(sp) - 8'd1);

  // R8
  pop_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && sp == 8'h00) |=> sp == 8'h00);

  // R7
  sp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= 8'h7F);

  // R9
  rbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_BRD) |=> $stable(rbit));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op == OP_RDB || op == OP_RDR || op == OP_RDI || op == OP_POP) |=> $stable(rdata));

  // R9
  nop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> $stable(sp));

endmodule

bind bitram_core bitram_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .op      (op),
  .sp      (stk_ptr),
  .rdata   (rdata),
  .rbit    (rbit),
  .push_ok (stk_push_ok)
);

// File: tb/bitram_core_tb.sv
module bitram_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] addr = 8'h00;
  logic [2:0] reg_idx = 3'd0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rbit;
  logic [7:0] stk_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];
  int sp_m;

  always #10 clk = ~clk;

  bitram_core dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .reg_idx(reg_idx),
    .bank_sel(bank_sel), .wdata(wdata), .rdata(rdata), .rbit(rbit), .stk_ptr(stk_ptr)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drives one operation at a falling edge; returns at the next falling edge.
  task automatic issue(input int o, input int a, input int idx, input int bk, input int wd);
    op = 4'(o); addr = 8'(a); reg_idx = 3'(idx); bank_sel = 2'(bk); wdata = 8'(wd);
    @(posedge clk);
    @(negedge clk);
    op = 4'd0;
  endtask

  function automatic int bit_home(input int b);
    if (b < 128) return 32 + b / 8;
    return b - (b % 8);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    sp_m = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sp", stk_ptr, 7);
    chk("R1 rdata", rdata, 0);
    chk("R1 rbit", rbit, 0);
    for (int a = 0; a < 256; a++) begin
      issue(1, a, 0, 0, 0);
      chk("R1 byte", rdata, 0);
    end

    // R2 byte sweep
    for (int a = 0; a < 256; a++) begin
      model[a] = 8'((a * 37 + 11) % 256);
      issue(2, a, 0, 0, model[a]);
    end
    for (int a = 0; a < 256; a++) begin
      issue(1, a, 0, 0, 0);
      chk("R2 byte", rdata, model[a]);
    end

    // R3 bank registers
    for (int bk = 0; bk < 4; bk++) begin
      for (int ix = 0; ix < 8; ix++) begin
        model[bk * 8 + ix] = 8'(200 - bk * 16 - ix);
        issue(4, 0, ix, bk, model[bk * 8 + ix]);
      end
    end
    for (int a = 0; a < 32; a++) begin
      issue(1, a, 0, 0, 0);
      chk("R3 via byte", rdata, model[a]);
      issue(3, 0, a % 8, a / 8, 0);
      chk("R3 via reg", rdata, model[a]);
    end
    issue(4, 0, 5, 3, 8'h77);
    model[29] = 8'h77;
    issue(1, 8'h1D, 0, 0, 0);
    chk("R3 bank3 R5 at 1DH", rdata, 8'h77);

    // R4/R5 bit sweep
    for (int b = 0; b < 256; b++) begin
      int y;
      int m;
      y = bit_home(b);
      m = 1 << (b % 8);
      issue(7, b, 0, 0, 0);
      model[y] = 8'(model[y] | m);
      issue(9, b, 0, 0, 0);
      chk("R4 bit read after set", rbit, 1);
      issue(1, y, 0, 0, 0);
      chk("R5 byte after set", rdata, model[y]);
      issue(8, b, 0, 0, 0);
      model[y] = 8'(model[y] & ~m);
      issue(9, b, 0, 0, 0);
      chk("R4 bit read after clear", rbit, 0);
      issue(1, y, 0, 0, 0);
      chk("R5 byte after clear", rdata, model[y]);
    end
    issue(2, 8'h2C, 0, 0, 8'h00); model[44] = 8'h00;
    issue(7, 8'h67, 0, 0, 0);     model[44] = 8'h80;
    issue(1, 8'h2C, 0, 0, 0);
    chk("R4 bit 67H is 2CH.7", rdata, 8'h80);
    issue(2, 8'hF0, 0, 0, 8'h0F); model[240] = 8'h0F;
    issue(7, 8'hF7, 0, 0, 0);     model[240] = 8'h8F;
    issue(1, 8'hF0, 0, 0, 0);
    chk("R4 bit F7H is F0H.7", rdata, 8'h8F);

    // R9 holds
    issue(1, 8'h2C, 0, 0, 0);
    issue(9, 8'h67, 0, 0, 0);
    issue(0, 0, 0, 0, 0);
    issue(2, 8'h50, 0, 0, 8'h11); model[80] = 8'h11;
    issue(8, 8'h00, 0, 0, 0);     model[32] = 8'(model[32] & 8'hFE);
    chk("R9 rdata held", rdata, 8'h80);
    chk("R9 rbit held", rbit, 1);
    chk("R9 nop sp held", stk_ptr, 7);

    // R6 indirect
    issue(4, 0, 0, 2, 8'h45); model[16] = 8'h45;
    issue(6, 0, 0, 2, 8'hA5); model[69] = 8'hA5;
    issue(1, 8'h45, 0, 0, 0);
    chk("R6 R0 indirect write", rdata, 8'hA5);
    issue(4, 0, 1, 2, 8'hC6); model[17] = 8'hC6;
    issue(6, 0, 1, 2, 8'h3C); model[70] = 8'h3C;
    issue(1, 8'h46, 0, 0, 0);
    chk("R6 pointer bit7 dropped", rdata, 8'h3C);
    issue(1, 8'hC6, 0, 0, 0);
    chk("R6 special byte untouched", rdata, model[198]);
    issue(5, 0, 1, 2, 0);
    chk("R6 indirect read", rdata, 8'h3C);

    // R7 push to the top
    for (int i = 0; i < 120; i++) begin
      int v;
      v = (i * 13 + 90) % 256;
      issue(10, 0, 0, 0, v);
      sp_m++;
      model[sp_m] = 8'(v);
      chk("R7 push sp", stk_ptr, sp_m);
    end
    issue(10, 0, 0, 0, 8'hEE);
    chk("R7 full push refused sp", stk_ptr, 8'h7F);
    issue(1, 8'h80, 0, 0, 0);
    chk("R7 full push no write", rdata, model[128]);

    // R8 pop to the floor
    for (int i = 0; i < 127; i++) begin
      issue(11, 0, 0, 0, 0);
      chk("R8 pop data", rdata, model[sp_m]);
      sp_m--;
      chk("R8 pop sp", stk_ptr, sp_m);
    end
    issue(11, 0, 0, 0, 0);
    chk("R8 pop at 00H data", rdata, model[0]);
    chk("R8 pop at 00H sp", stk_ptr, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule